// File: doc/BRIEF.md
# Staged Shadow Register Update Controller

This block is a two-bank control register file loaded through a 24-bit serial write port. Every stored register has a shadow copy, which each write updates, and an active copy, which drives the outputs. The shadow value moves to the active copy at a point fixed by the register's update class. Some registers take their value as soon as the frame completes. Some wait for the vertical sync falling edge, and in bank 1 that wait can be pushed back to a chosen horizontal line. Some wait for the horizontal falling edge that closes the sensor-gate line. Sequence registers wait for the next change point that selects their sequence.

A per-register pending flag is set by a write and cleared by the commit. A later event therefore never reapplies a value that has already been committed, and when several writes arrive before the commit event only the last one counts. The class of each register is fixed by a lookup on bank and address. The serial clock, VD and HD are sampled by the system clock, so all events are edges seen in that clock domain.

Top module: `stg_shadow_regs`

## Requirements
- R1: A write frame is open while `sload` is high. One bit is taken on each rising edge of `sclk`, least significant bit first. Bits 0 to 7 form the address and bits 8 to 23 the data. Dropping `sload` before the 24th bit discards the partial frame, and the next frame starts counting from bit 0.
- R2: Bank-1 addresses 0x00 to 0x03 and 0x19 (the line-delay register), and address 0x7F in either bank, are immediate: the active value follows the write with no frame event.
- R3: Writing address 0x7F sets `bank_sel` to data bit 0, with 0 selecting bank 1 and 1 selecting bank 2 for later writes. `bank_sel` changes on no other input.
- R4: With the line delay (bank-1 0x19, low 10 bits) at zero, bank-1 registers 0x08 to 0x1F other than 0x19 commit at the VD falling edge.
- R5: With a line delay D other than zero, those bank-1 registers commit at the D-th HD falling edge after the VD falling edge, not at the VD edge. The line count restarts at each VD falling edge.
- R6: Bank-2 field registers at 0xD0 to 0xD3 commit at the VD falling edge whatever the line delay.
- R7: Bank-1 registers 0x04 to 0x07 commit at an HD falling edge while `sg_line` is high. An HD falling edge with `sg_line` low leaves them unchanged.
- R8: Bank-2 registers 0x00 to 0x0F belong to sequence address bits [3:2]. They commit on a cycle with `scp` high and `scp_seq` equal to that sequence. A change point for another sequence leaves them unchanged.
- R9: When a register is written several times before its commit event, the active copy takes the last value written.
- R10: Writes to addresses with no storage (bank 1 at 0x20 and above except 0x7F, bank 2 at 0x10 to 0xCF except 0x7F, and above 0xD3) change no output, now or at any later event.
- R11: A synchronous reset clears all active copies, all shadow copies and all pending flags, and sets `bank_sel` to 0. A frame event after reset leaves every output at zero.
- R12: Bank-1 register at address a appears at `b1_active[16a +: 16]`. In bank 2, address a below 0x10 appears at `b2_active[16a +: 16]`, and field address 0xD0+k appears at `b2_active[16(16+k) +: 16]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial bit clock, rising edge takes a bit |
| sdata | input | 1 | Serial data bit |
| sload | input | 1 | Frame enable, high while a frame is sent |
| vd | input | 1 | Vertical sync, falling edge marks a field start |
| hd | input | 1 | Horizontal sync, falling edge ends a line |
| sg_line | input | 1 | High during the sensor-gate active line |
| scp | input | 1 | Sequence change point strobe, one clock wide |
| scp_seq | input | SEQ_W (2) | Sequence index selected at the change point |
| bank_sel | output | 1 | Current write bank (0 bank 1, 1 bank 2) |
| b1_active | output | B1_REGS*DATA_W (512) | Active bank-1 values, packed by address |
| b2_active | output | (NUM_SEQ*REGS_PER_SEQ+FIELD_REGS)*DATA_W (320) | Active bank-2 values, sequence then field registers |

## Verification
The block is exercised with writes followed by each kind of frame event: VD falls with zero and nonzero line delay, HD falls with the sensor-gate flag high and low, and change points for matching and non-matching sequences. These patterns tell apart the update classes, because a register committed by the wrong event shows up at once as an early or missing change. Repeated writes before one event separate last-value-wins from first-value-wins. A frame aborted midway followed by a full one shows whether the bit counter restarts. A long random mix of frames, bank switches, delay changes and events, checked against a bench model of shadow, active and pending state, catches a pending flag that fails to clear or a line count that does not restart at VD.

// File: rtl/stg_pkg.sv
package stg_pkg;

   typedef enum logic [1:0] {
      UPD_IMM,
      UPD_VD,
      UPD_SG,
      UPD_SEQ
   } upd_cls_e;

   localparam logic [7:0] BANKSEL_ADDR = 8'h7F;
   localparam logic [7:0] DELAY_ADDR   = 8'h19;
   localparam logic [7:0] FIELD_BASE   = 8'hD0;
   localparam int         IMM_LAST     = 3;
   localparam int         SG_FIRST     = 4;
   localparam int         SG_LAST      = 7;

   // Fixed class lookup for bank-1 storage; anything not listed is VD class.
   function automatic upd_cls_e bank1_class(input int addr);
      if (addr <= IMM_LAST || addr == int'(DELAY_ADDR))
         return UPD_IMM;
      else if (addr >= SG_FIRST && addr <= SG_LAST)
         return UPD_SG;
      else
         return UPD_VD;
   endfunction

endpackage

// File: rtl/stg_serial_rx.sv
module stg_serial_rx #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk,
   input  logic              sdata,
   input  logic              sload,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int FRAME_W = ADDR_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W);

   logic               sclk_q;
   logic               sclk_rise;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] shift_q;
   logic [FRAME_W-1:0] word_q;

   assign sclk_rise = sclk & ~sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q   <= 1'b0;
         bit_cnt  <= '0;
         shift_q  <= '0;
         word_q   <= '0;
         wr_valid <= 1'b0;
      end else begin
         sclk_q   <= sclk;
         wr_valid <= 1'b0;
         if (!sload) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            shift_q <= {sdata, shift_q[FRAME_W-1:1]};
            if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
               bit_cnt  <= '0;
               word_q   <= {sdata, shift_q[FRAME_W-1:1]};
               wr_valid <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign wr_addr = word_q[ADDR_W-1:0];
   assign wr_data = word_q[FRAME_W-1:ADDR_W];

endmodule

// File: rtl/stg_frame_events.sv
module stg_frame_events #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vd,
   input  logic              hd,
   input  logic              sg_line,
   input  logic [LINE_W-1:0] line_delay,
   output logic              vd_fall,
   output logic              hd_fall,
   output logic              sg_end,
   output logic              b1_vd_commit,
   output logic [LINE_W-1:0] line_cnt
);

   logic              vd_q;
   logic              hd_q;
   logic              armed;
   logic [LINE_W-1:0] line_next;
   logic              line_hit;

   assign vd_fall   = vd_q & ~vd;
   assign hd_fall   = hd_q & ~hd;
   assign sg_end    = hd_fall & sg_line;
   assign line_next = line_cnt + 1'b1;
   assign line_hit  = hd_fall && armed && (line_next == line_delay);

   assign b1_vd_commit = (vd_fall && (line_delay == '0)) || line_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         vd_q     <= 1'b1;
         hd_q     <= 1'b1;
         armed    <= 1'b0;
         line_cnt <= '0;
      end else begin
         vd_q <= vd;
         hd_q <= hd;
         if (vd_fall) begin
            line_cnt <= '0;
            armed    <= (line_delay != '0);
         end else begin
            if (hd_fall)
               line_cnt <= line_next;
            if (line_hit)
               armed <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/stg_reg_slot.sv
module stg_reg_slot #(
   parameter int DATA_W    = 16,
   parameter bit IMMEDIATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   output logic [DATA_W-1:0] active
);

   logic [DATA_W-1:0] shadow;
   logic              pending;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow  <= '0;
         active  <= '0;
         pending <= 1'b0;
      end else begin
         if (commit && pending) begin
            active  <= shadow;
            pending <= 1'b0;
         end
         if (wr) begin
            shadow <= wdata;
            if (IMMEDIATE)
               active <= wdata;
            else
               pending <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/stg_shadow_regs.sv
module stg_shadow_regs #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 16,
   parameter int B1_REGS      = 32,
   parameter int NUM_SEQ      = 4,
   parameter int REGS_PER_SEQ = 4,
   parameter int FIELD_REGS   = 4,
   parameter int LINE_W       = 10,
   parameter int SEQ_W        = $clog2(NUM_SEQ)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sclk,
   input  logic                 sdata,
   input  logic                 sload,
   input  logic                 vd,
   input  logic                 hd,
   input  logic                 sg_line,
   input  logic                 scp,
   input  logic [SEQ_W-1:0]     scp_seq,
   output logic                 bank_sel,
   output logic [B1_REGS*DATA_W-1:0] b1_active,
   output logic [(NUM_SEQ*REGS_PER_SEQ+FIELD_REGS)*DATA_W-1:0] b2_active
);

   import stg_pkg::*;

   localparam int SEQ_REGS = NUM_SEQ * REGS_PER_SEQ;
   localparam int B2_REGS  = SEQ_REGS + FIELD_REGS;
   localparam int DLY_IDX  = int'(DELAY_ADDR);

   if (ADDR_W != 8)                    $error("address field must be 8 bits");
   if (ADDR_W + DATA_W != 24)          $error("frame must be 24 bits");
   if (B1_REGS <= DLY_IDX)             $error("bank 1 must hold the delay register");
   if (B1_REGS > int'(BANKSEL_ADDR))   $error("bank 1 overlaps bank select");
   if (SEQ_REGS > int'(BANKSEL_ADDR))  $error("sequence registers overlap bank select");
   if (FIELD_REGS > 256 - int'(FIELD_BASE)) $error("field registers exceed address space");
   if (LINE_W > DATA_W)                $error("line delay wider than data");
   if (NUM_SEQ < 2)                    $error("at least two sequences needed");

   logic              wr_valid;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              vd_fall;
   logic              hd_fall;
   logic              sg_end;
   logic              b1_vd_commit;
   logic [LINE_W-1:0] line_cnt;
   logic [LINE_W-1:0] line_delay;

   stg_serial_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst      (rst),
      .sclk     (sclk),
      .sdata    (sdata),
      .sload    (sload),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   assign line_delay = b1_active[DLY_IDX*DATA_W +: LINE_W];

   stg_frame_events #(.LINE_W(LINE_W)) u_events (
      .clk          (clk),
      .rst          (rst),
      .vd           (vd),
      .hd           (hd),
      .sg_line      (sg_line),
      .line_delay   (line_delay),
      .vd_fall      (vd_fall),
      .hd_fall      (hd_fall),
      .sg_end       (sg_end),
      .b1_vd_commit (b1_vd_commit),
      .line_cnt     (line_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst)
         bank_sel <= 1'b0;
      else if (wr_valid && wr_addr == BANKSEL_ADDR)
         bank_sel <= wr_data[0];
   end

   for (genvar i = 0; i < B1_REGS; i++) begin : g_b1
      localparam upd_cls_e CLS = bank1_class(i);
      logic wr;
      logic commit;

      assign wr = wr_valid && !bank_sel && (wr_addr == ADDR_W'(i));

      if (CLS == UPD_IMM) begin : g_imm
         assign commit = 1'b0;
      end else if (CLS == UPD_SG) begin : g_sg
         assign commit = sg_end;
      end else begin : g_vd
         assign commit = b1_vd_commit;
      end

      stg_reg_slot #(
         .DATA_W    (DATA_W),
         .IMMEDIATE (CLS == UPD_IMM ? 1'b1 : 1'b0)
      ) u_slot (
         .clk    (clk),
         .rst    (rst),
         .wr     (wr),
         .wdata  (wr_data),
         .commit (commit),
         .active (b1_active[i*DATA_W +: DATA_W])
      );
   end

   for (genvar j = 0; j < B2_REGS; j++) begin : g_b2
      localparam bit IS_SEQ = (j < SEQ_REGS);
      localparam int ADDR   = IS_SEQ ? j : int'(FIELD_BASE) + j - SEQ_REGS;
      localparam int SEQ_ID = IS_SEQ ? j / REGS_PER_SEQ : 0;
      logic wr;
      logic commit;

      assign wr = wr_valid && bank_sel && (wr_addr == ADDR_W'(ADDR));

      if (IS_SEQ) begin : g_seq
         assign commit = scp && (scp_seq == SEQ_W'(SEQ_ID));
      end else begin : g_field
         assign commit = vd_fall;
      end

      stg_reg_slot #(.DATA_W(DATA_W), .IMMEDIATE(1'b0)) u_slot (
         .clk    (clk),
         .rst    (rst),
         .wr     (wr),
         .wdata  (wr_data),
         .commit (commit),
         .active (b2_active[j*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/stg_shadow_regs_chk.sv
module stg_shadow_regs_chk #(
   parameter int B1_W   = 512,
   parameter int B2_W   = 320,
   parameter int LINE_W = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_valid,
   input logic              vd_fall,
   input logic              hd_fall,
   input logic              scp,
   input logic [LINE_W-1:0] line_cnt,
   input logic              bank_sel,
   input logic [B1_W-1:0]   b1_active,
   input logic [B2_W-1:0]   b2_active
);

   logic rst_q;

   always_ff @(posedge clk) rst_q <= rst;

   // R11: one edge after reset every output sits at its cleared value
   always @(posedge clk) begin
      if (rst_q === 1'b1) begin
         assert_reset_clear_R11: assert (bank_sel == 1'b0 && b1_active == '0 && b2_active == '0)
            else $error("outputs not cleared by reset");
      end
   end

   // R4 R5 R7: bank 1 only moves on a completed write or a VD/HD edge
   assert_b1_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!wr_valid && !vd_fall && !hd_fall) |=> $stable(b1_active));

   // R8 R6: bank 2 only moves on a completed write, a VD edge or a change point
   assert_b2_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!wr_valid && !vd_fall && !scp) |=> $stable(b2_active));

   assert_bank_sel_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !wr_valid |=> $stable(bank_sel));

   assert_line_restart_R5: assert property (@(posedge clk) disable iff (rst)
      vd_fall |=> (line_cnt == '0));

endmodule

bind stg_shadow_regs stg_shadow_regs_chk #(
   .B1_W   (B1_REGS * DATA_W),
   .B2_W   ((NUM_SEQ * REGS_PER_SEQ + FIELD_REGS) * DATA_W),
   .LINE_W (LINE_W)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .wr_valid  (wr_valid),
   .vd_fall   (vd_fall),
   .hd_fall   (hd_fall),
   .scp       (scp),
   .line_cnt  (line_cnt),
   .bank_sel  (bank_sel),
   .b1_active (b1_active),
   .b2_active (b2_active)
);

// File: tb/stg_shadow_regs_tb_top.sv
module stg_shadow_regs_tb_top;

   localparam int DW    = 16;
   localparam int NB1   = 32;
   localparam int NSEQR = 16;
   localparam int NB2   = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
   logic vd = 1'b1, hd = 1'b1, sg_line = 1'b0, scp = 1'b0;
   logic [1:0] scp_seq = 2'd0;
   logic bank_sel;
   logic [NB1*DW-1:0] b1_active;
   logic [NB2*DW-1:0] b2_active;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [DW-1:0] sh1 [NB1];
   logic [DW-1:0] ac1 [NB1];
   bit            pd1 [NB1];
   logic [DW-1:0] sh2 [NB2];
   logic [DW-1:0] ac2 [NB2];
   bit            pd2 [NB2];
   bit            m_bank;
   logic [9:0]    m_line;
   bit            m_armed;

   always #2 clk = ~clk;

   stg_shadow_regs dut_i (
      .clk (clk), .rst (rst), .sclk (sclk), .sdata (sdata), .sload (sload),
      .vd (vd), .hd (hd), .sg_line (sg_line), .scp (scp), .scp_seq (scp_seq),
      .bank_sel (bank_sel), .b1_active (b1_active), .b2_active (b2_active)
   );

   // 0 immediate, 1 vd, 2 sg
   function automatic int b1_cls(input int a);
      if (a <= 3 || a == 25) return 0;
      if (a >= 4 && a <= 7) return 2;
      return 1;
   endfunction

   function automatic int b2_index(input int a);
      if (a < NSEQR) return a;
      if (a >= 8'hD0 && a < 8'hD0 + 4) return NSEQR + a - 8'hD0;
      return -1;
   endfunction

   function automatic logic [9:0] m_delay();
      return ac1[25][9:0];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NB1; i++) begin sh1[i] = '0; ac1[i] = '0; pd1[i] = 0; end
      for (int i = 0; i < NB2; i++) begin sh2[i] = '0; ac2[i] = '0; pd2[i] = 0; end
      m_bank = 0; m_line = '0; m_armed = 0;
   endtask

   task automatic commit_b1(input int cls);
      for (int i = 0; i < NB1; i++)
         if (b1_cls(i) == cls && pd1[i]) begin ac1[i] = sh1[i]; pd1[i] = 0; end
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic send_bits(input logic [23:0] w, input int n);
      sload = 1'b1;
      for (int b = 0; b < n; b++) begin
         sdata = w[b]; sclk = 1'b0; wait_n(2);
         sclk = 1'b1; wait_n(2);
      end
      sclk = 1'b0; wait_n(2);
      sload = 1'b0; wait_n(3);
   endtask

   task automatic write_reg(input int a, input logic [15:0] d);
      int idx;
      send_bits({d, 8'(a)}, 24);
      if (a == 8'h7F) m_bank = d[0];
      else if (!m_bank) begin
         if (a < NB1) begin
            sh1[a] = d;
            if (b1_cls(a) == 0) ac1[a] = d; else pd1[a] = 1;
         end
      end else begin
         idx = b2_index(a);
         if (idx >= 0) begin sh2[idx] = d; pd2[idx] = 1; end
      end
   endtask

   task automatic pulse_vd();
      vd = 1'b0; wait_n(3); vd = 1'b1; wait_n(2);
      for (int j = NSEQR; j < NB2; j++)
         if (pd2[j]) begin ac2[j] = sh2[j]; pd2[j] = 0; end
      m_line = '0;
      if (m_delay() == '0) begin commit_b1(1); m_armed = 0; end
      else m_armed = 1;
   endtask

   task automatic pulse_hd(input bit sg);
      sg_line = sg; wait_n(1);
      hd = 1'b0; wait_n(3); hd = 1'b1; wait_n(1);
      sg_line = 1'b0; wait_n(1);
      if (sg) commit_b1(2);
      m_line = m_line + 10'd1;
      if (m_armed && m_line == m_delay()) begin commit_b1(1); m_armed = 0; end
   endtask

   task automatic pulse_scp(input int s);
      scp_seq = 2'(s); scp = 1'b1; wait_n(1); scp = 1'b0; wait_n(2);
      for (int j = 0; j < NSEQR; j++)
         if (j / 4 == s && pd2[j]) begin ac2[j] = sh2[j]; pd2[j] = 0; end
   endtask

   task automatic check_all(input string req);
      checks++;
      if (bank_sel !== m_bank) begin
         errors++;
         $display("FAIL %s bank_sel got %0b exp %0b", req, bank_sel, m_bank);
      end
      for (int i = 0; i < NB1; i++) begin
         checks++;
         if (b1_active[i*DW +: DW] !== ac1[i]) begin
            errors++;
            $display("FAIL %s bank1 reg %0d got %h exp %h", req, i, b1_active[i*DW +: DW], ac1[i]);
         end
      end
      for (int j = 0; j < NB2; j++) begin
         checks++;
         if (b2_active[j*DW +: DW] !== ac2[j]) begin
            errors++;
            $display("FAIL %s bank2 slot %0d got %h exp %h", req, j, b2_active[j*DW +: DW], ac2[j]);
         end
      end
   endtask

   task automatic random_op();
      int r, a;
      logic [15:0] d;
      r = int'($urandom % 10);
      d = 16'($urandom);
      case (r)
         0, 1, 2, 3, 4: begin
            if (!m_bank) begin
               a = int'($urandom % 34);
               if (a == 32) a = 8'h7F; else if (a == 33) a = 8'h40;
            end else begin
               a = int'($urandom % 22);
               if (a >= 16 && a < 20) a = 8'hD0 + a - 16;
               else if (a == 20) a = 8'h7F; else if (a == 21) a = 8'h80;
            end
            if (a == 25) d = 16'($urandom % 4);
            write_reg(a, d);
         end
         5: pulse_vd();
         6, 7: pulse_hd(bit'($urandom % 2));
         8: pulse_scp(int'($urandom % 4));
         default: write_reg(8'h7F, 16'($urandom % 2));
      endcase
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd4721);
      model_reset();
      wait_n(4);
      rst = 1'b0;
      wait_n(2);
      check_all("R11 reset state");
      pulse_vd(); pulse_hd(1); pulse_scp(0);
      check_all("R11 events after reset");

      // R2 immediate bank-1 registers
      write_reg(2, 16'hA5C3);
      check_all("R2 immediate write");

      // R4 VD class waits for VD fall
      write_reg(8'h10, 16'h1234);
      check_all("R4 before VD");
      pulse_vd();
      check_all("R4 after VD");

      // R9 last write wins
      write_reg(8'h11, 16'h1111);
      write_reg(8'h11, 16'h2222);
      pulse_vd();
      check_all("R9 last write");

      // R7 SG class
      write_reg(5, 16'h5A5A);
      pulse_hd(0);
      check_all("R7 hd without sg_line");
      pulse_hd(1);
      check_all("R7 sg line end");

      // R1 aborted frame then full frame
      send_bits(24'hFFFF03, 10);
      check_all("R1 partial frame discarded");
      write_reg(3, 16'h0F0F);
      check_all("R1 full frame after abort");

      // R3 bank select, R8 sequence commits, R6 field registers
      write_reg(8'h7F, 16'h0001);
      check_all("R3 bank select to bank 2");
      write_reg(8'h06, 16'hBEEF);
      pulse_scp(0);
      check_all("R8 other sequence ignored");
      pulse_scp(1);
      check_all("R8 matching sequence");
      write_reg(8'hD1, 16'hCAFE);
      write_reg(8'h40, 16'hDEAD);
      write_reg(8'hD7, 16'hDEAD);

      // R5 delayed bank-1 commit with R6 unaffected
      write_reg(8'h7F, 16'h0000);
      write_reg(8'h19, 16'd3);
      write_reg(8'h12, 16'h7777);
      write_reg(8'h30, 16'hDEAD);
      pulse_vd();
      check_all("R6 field at VD despite delay");
      pulse_hd(0); pulse_hd(0);
      check_all("R5 held before delay line");
      pulse_hd(0);
      check_all("R5 commit at delay line");
      pulse_vd(); pulse_scp(2); pulse_hd(1);
      check_all("R10 unmapped writes ignored");
      check_all("R12 layout");
      write_reg(8'h19, 16'd0);

      for (int n = 0; n < 400; n++) begin
         random_op();
         check_all("R4 R5 R8 random mix");
      end

      rst = 1'b1; wait_n(2); rst = 1'b0; model_reset(); wait_n(1);
      pulse_vd();
      check_all("R11 reset clears pending");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule